// File: doc/BRIEF.md
# Masked Data-Address Breakpoint Unit

This block watches the data accesses of a processor pipeline and raises a debug trap when an access falls inside one of several watched address regions. Each breakpoint has an address register and a control register. The control register holds a load-enable bit, a store-enable bit and a six-bit mask field. The mask field selects a power-of-two aligned window around the stored address. Each presented access carries its address, its direction, the program counter of the instruction that issued it and the current status word. The block compares every enabled breakpoint against the access in parallel.

When at least one breakpoint matches, the block reports the hit in the following cycle. If the interrupt level in the status word is below the configured debug level, the block also performs the bookkeeping for entry into the debug exception. It stores a cause word that lists every matching breakpoint and names the lowest-indexed one as primary. It saves the program counter and the incoming status word. It then produces a new status word with the interrupt level raised to the debug level and exception mode set. Software programs the breakpoints through a single write port. Every register, including the saved debug state, can be read back through a registered read port.

Top module: `dbrk_unit`

## Requirements
- R1: After synchronous reset, all breakpoint address and control registers, the cause, saved PC and saved status read as zero, and `bp_hit`, `dbg_take` and `dbg_status` are zero.
- R2: Register index = {kind[1:0], idx}. Kind 0 is the breakpoint address and kind 1 is the control word: bit 31 load-enable, bit 30 store-enable, bits 5:0 mask field, all other bits reading zero. Kind 2 with idx 0 is the cause, kind 2 with idx other than 0 is the saved PC, and kind 3 is the saved status. Writes to kinds 2 and 3 are ignored. `rd_data` is valid the cycle after `rd_en`.
- R3: The effective mask is all ones above bit 5, with the mask field in bits 5:0. An access matches when `(acc_addr ^ bp_addr) & mask` is zero. A field made of k leading ones followed by zeros watches an aligned block of 2^(6-k) bytes.
- R4: A mask field that is not contiguous is repaired by keeping only its leading run of ones from bit 5 downward. For example, 6'b101111 behaves as 6'b100000, and 6'b011111 behaves as 6'b000000.
- R5: A store can match only if store-enable is set, and a load only if load-enable is set. With both bits clear the breakpoint never matches. No match occurs while `acc_valid` is low.
- R6: `bp_hit` is high in the cycle after an access that matched at least one breakpoint, and low otherwise.
- R7: Debug entry (`dbg_take`, one cycle after the access) occurs only on a hit where the status interrupt level (bits 3:0) is below `DBG_LEVEL`. A hit at or above that level raises `bp_hit` alone.
- R8: On entry, the cause word has bit 0 set, the primary (lowest matching) index in bits starting at 8, and the full hit vector in bits starting at 16.
- R9: On entry, the saved PC takes `acc_pc` and the saved status takes `acc_status`.
- R10: On entry, `dbg_status` equals `acc_status` with bits 3:0 replaced by `DBG_LEVEL` and bit 4 (exception mode) set.
- R11: Without entry, the cause, saved PC, saved status and `dbg_status` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | IDX_W+2 | Register index for write |
| wr_data | input | AW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | IDX_W+2 | Register index for read |
| rd_data | output | AW | Registered read data |
| acc_valid | input | 1 | Data access present |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | AW | Access address |
| acc_pc | input | AW | PC of the accessing instruction |
| acc_status | input | AW | Current status word |
| bp_hit | output | 1 | A breakpoint matched the previous access |
| dbg_take | output | 1 | Debug entry taken for the previous access |
| dbg_cause | output | AW | Cause word of the last entry |
| dbg_epc | output | AW | Saved PC of the last entry |
| dbg_eps | output | AW | Saved status of the last entry |
| dbg_status | output | AW | Updated status word of the last entry |

## Verification
The bench builds the block with its defaults: two breakpoints, a 32-bit address and a six-bit mask field. A six-bit field means all 64 mask codes can be swept on one breakpoint. Each code is probed with single-bit address flips across the low byte, so every contiguous region size and every repaired non-contiguous code is checked against a mask the bench derives by counting leading ones. With two breakpoints, both simultaneous hits and single hits can be reached, which exercises the primary-index priority. A debug level of 6 lets the bench place the status level both just below and exactly at the threshold.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  // control word bit positions
  localparam int LD_BIT   = 31;
  localparam int ST_BIT   = 30;
  // status word fields
  localparam int LVL_LSB  = 0;
  localparam int LVL_W    = 4;
  localparam int EXCM_BIT = 4;
  // cause word fields
  localparam int CAUSE_IDX_LSB = 8;
  localparam int CAUSE_VEC_LSB = 16;

  typedef enum logic [1:0] {
    RK_ADDR  = 2'd0,
    RK_CTRL  = 2'd1,
    RK_CSPC  = 2'd2,
    RK_EPS   = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/dbrk_mask.sv
// Builds the effective comparison mask from a mask field, repairing
// a non-contiguous pattern to its leading run of ones.
module dbrk_mask #(
  parameter int AW     = 32,
  parameter int MASK_W = 6
) (
  input  logic [MASK_W-1:0] field,
  output logic [AW-1:0]     eff_mask
);
  localparam int LW = $clog2(AW + 1);

  logic [AW-1:0] raw;
  logic [AW-1:0] inv;
  logic [AW-1:0] probe;
  logic [LW-1:0] lead;
  logic          seen_zero;

  always_comb begin
    raw   = {{(AW-MASK_W){1'b1}}, field};
    inv   = ~raw;
    probe = (inv + {{(AW-1){1'b0}}, 1'b1}) & inv;
    lead      = '0;
    seen_zero = 1'b0;
    for (int b = AW - 1; b >= 0; b--) begin
      if (!seen_zero && raw[b]) lead = lead + LW'(1);
      else                      seen_zero = 1'b1;
    end
    if (probe != '0) eff_mask = {AW{1'b1}} << (AW - int'(lead));
    else             eff_mask = raw;
  end
endmodule

// File: rtl/dbrk_match.sv
// Compares one access against one breakpoint.
module dbrk_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] eff_mask,
  input  logic [AW-1:0] bp_addr,
  input  logic          ld_en,
  input  logic          st_en,
  input  logic          acc_valid,
  input  logic          acc_store,
  input  logic [AW-1:0] acc_addr,
  output logic          hit
);
  logic kind_ok;
  logic addr_ok;

  always_comb begin
    kind_ok = acc_store ? st_en : ld_en;
    addr_ok = ((acc_addr ^ bp_addr) & eff_mask) == '0;
    hit     = acc_valid && kind_ok && addr_ok;
  end
endmodule

// File: rtl/dbrk_regs.sv
// Breakpoint address and control storage with the write decoder.
module dbrk_regs #(
  parameter int NUM_BP = 2,
  parameter int AW     = 32,
  parameter int MASK_W = 6,
  parameter int IDX_W  = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W+1:0]        wr_addr,
  input  logic [AW-1:0]           wr_data,
  output logic [NUM_BP-1:0][AW-1:0]     bp_addr,
  output logic [NUM_BP-1:0]             bp_ld,
  output logic [NUM_BP-1:0]             bp_st,
  output logic [NUM_BP-1:0][MASK_W-1:0] bp_field
);
  import dbrk_pkg::*;

  logic [1:0]       wkind;
  logic [IDX_W-1:0] widx;

  assign wkind = wr_addr[IDX_W+1:IDX_W];
  assign widx  = wr_addr[IDX_W-1:0];

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    logic sel;
    assign sel = wr_en && (widx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        bp_addr[g]  <= '0;
        bp_ld[g]    <= 1'b0;
        bp_st[g]    <= 1'b0;
        bp_field[g] <= '0;
      end else if (sel) begin
        if (wkind == RK_ADDR) bp_addr[g] <= wr_data;
        if (wkind == RK_CTRL) begin
          bp_ld[g]    <= wr_data[LD_BIT];
          bp_st[g]    <= wr_data[ST_BIT];
          bp_field[g] <= wr_data[MASK_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/dbrk_entry.sv
// Priority selection and debug-entry bookkeeping registers.
module dbrk_entry #(
  parameter int NUM_BP    = 2,
  parameter int AW        = 32,
  parameter int IDX_W     = 1,
  parameter int DBG_LEVEL = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_BP-1:0] hit_vec,
  input  logic [AW-1:0]     acc_pc,
  input  logic [AW-1:0]     acc_status,
  output logic              bp_hit,
  output logic              dbg_take,
  output logic [AW-1:0]     dbg_cause,
  output logic [AW-1:0]     dbg_epc,
  output logic [AW-1:0]     dbg_eps,
  output logic [AW-1:0]     dbg_status
);
  import dbrk_pkg::*;

  logic [IDX_W-1:0] prim;
  logic             any_hit;
  logic             level_ok;
  logic             enter;
  logic [AW-1:0]    nxt_status;
  logic [AW-1:0]    nxt_cause;

  always_comb begin
    prim = '0;
    for (int i = NUM_BP - 1; i >= 0; i--) begin
      if (hit_vec[i]) prim = IDX_W'(i);
    end
    any_hit  = |hit_vec;
    level_ok = acc_status[LVL_LSB +: LVL_W] < LVL_W'(DBG_LEVEL);
    enter    = any_hit && level_ok;

    nxt_status = acc_status;
    nxt_status[LVL_LSB +: LVL_W] = LVL_W'(DBG_LEVEL);
    nxt_status[EXCM_BIT]         = 1'b1;

    nxt_cause = '0;
    nxt_cause[0] = 1'b1;
    nxt_cause[CAUSE_IDX_LSB +: IDX_W]  = prim;
    nxt_cause[CAUSE_VEC_LSB +: NUM_BP] = hit_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_hit     <= 1'b0;
      dbg_take   <= 1'b0;
      dbg_cause  <= '0;
      dbg_epc    <= '0;
      dbg_eps    <= '0;
      dbg_status <= '0;
    end else begin
      bp_hit   <= any_hit;
      dbg_take <= enter;
      if (enter) begin
        dbg_cause  <= nxt_cause;
        dbg_epc    <= acc_pc;
        dbg_eps    <= acc_status;
        dbg_status <= nxt_status;
      end
    end
  end
endmodule

// File: rtl/dbrk_unit.sv
// Top level: breakpoint storage, parallel matchers, entry logic, readback.
module dbrk_unit #(
  parameter int NUM_BP    = 2,
  parameter int AW        = 32,
  parameter int MASK_W    = 6,
  parameter int DBG_LEVEL = 6,
  localparam int IDX_W    = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W+1:0] wr_addr,
  input  logic [AW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic [IDX_W+1:0] rd_addr,
  output logic [AW-1:0]    rd_data,
  input  logic             acc_valid,
  input  logic             acc_store,
  input  logic [AW-1:0]    acc_addr,
  input  logic [AW-1:0]    acc_pc,
  input  logic [AW-1:0]    acc_status,
  output logic             bp_hit,
  output logic             dbg_take,
  output logic [AW-1:0]    dbg_cause,
  output logic [AW-1:0]    dbg_epc,
  output logic [AW-1:0]    dbg_eps,
  output logic [AW-1:0]    dbg_status
);
  import dbrk_pkg::*;

  logic [NUM_BP-1:0][AW-1:0]     bp_addr;
  logic [NUM_BP-1:0]             bp_ld;
  logic [NUM_BP-1:0]             bp_st;
  logic [NUM_BP-1:0][MASK_W-1:0] bp_field;
  logic [NUM_BP-1:0][AW-1:0]     bp_mask;
  logic [NUM_BP-1:0]             hit_vec;

  dbrk_regs #(.NUM_BP(NUM_BP), .AW(AW), .MASK_W(MASK_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bp_addr(bp_addr), .bp_ld(bp_ld), .bp_st(bp_st), .bp_field(bp_field)
  );

  for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
    dbrk_mask #(.AW(AW), .MASK_W(MASK_W)) u_mask (
      .field(bp_field[g]), .eff_mask(bp_mask[g])
    );
    dbrk_match #(.AW(AW)) u_match (
      .eff_mask(bp_mask[g]), .bp_addr(bp_addr[g]),
      .ld_en(bp_ld[g]), .st_en(bp_st[g]),
      .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
      .hit(hit_vec[g])
    );
  end

  dbrk_entry #(.NUM_BP(NUM_BP), .AW(AW), .IDX_W(IDX_W), .DBG_LEVEL(DBG_LEVEL)) u_entry (
    .clk(clk), .rst(rst), .hit_vec(hit_vec), .acc_pc(acc_pc), .acc_status(acc_status),
    .bp_hit(bp_hit), .dbg_take(dbg_take), .dbg_cause(dbg_cause),
    .dbg_epc(dbg_epc), .dbg_eps(dbg_eps), .dbg_status(dbg_status)
  );

  // readback
  logic [1:0]       rkind;
  logic [IDX_W-1:0] ridx;
  logic             ridx_ok;
  logic [AW-1:0]    rd_word;

  assign rkind   = rd_addr[IDX_W+1:IDX_W];
  assign ridx    = rd_addr[IDX_W-1:0];
  assign ridx_ok = int'(ridx) < NUM_BP;

  always_comb begin
    rd_word = '0;
    unique case (rkind)
      RK_ADDR: if (ridx_ok) rd_word = bp_addr[ridx];
      RK_CTRL: if (ridx_ok) begin
        rd_word[LD_BIT]       = bp_ld[ridx];
        rd_word[ST_BIT]       = bp_st[ridx];
        rd_word[MASK_W-1:0]   = bp_field[ridx];
      end
      RK_CSPC: rd_word = (ridx == '0) ? dbg_cause : dbg_epc;
      RK_EPS:  rd_word = dbg_eps;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end
endmodule

// File: rtl/dbrk_unit_chk.sv
module dbrk_unit_chk #(
  parameter int NUM_BP    = 2,
  parameter int AW        = 32,
  parameter int DBG_LEVEL = 6,
  parameter int IDX_W     = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic [AW-1:0] acc_pc,
  input logic [AW-1:0] acc_status,
  input logic          bp_hit,
  input logic          dbg_take,
  input logic [AW-1:0] dbg_cause,
  input logic [AW-1:0] dbg_epc,
  input logic [AW-1:0] dbg_eps,
  input logic [AW-1:0] dbg_status
);
  logic [NUM_BP-1:0] c_vec;
  logic [IDX_W-1:0]  c_prim;
  logic [NUM_BP-1:0] below_prim;

  assign c_vec      = dbg_cause[16 +: NUM_BP];
  assign c_prim     = dbg_cause[8 +: IDX_W];
  assign below_prim = c_vec & ((NUM_BP'(1) << c_prim) - NUM_BP'(1));

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    bp_hit |-> $past(acc_valid)); // R6
  AST_TAKE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    dbg_take |-> bp_hit); // R7
  AST_TAKE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    dbg_take |-> ($past(acc_status[3:0]) < 4'(DBG_LEVEL))); // R7
  AST_CAUSE_PRIMARY: assert property (@(posedge clk) disable iff (rst)
    dbg_take |-> (dbg_cause[0] && c_vec[c_prim] && below_prim == '0)); // R8
  AST_SAVE_PC: assert property (@(posedge clk) disable iff (rst)
    dbg_take |-> (dbg_epc == $past(acc_pc) && dbg_eps == $past(acc_status))); // R9
  AST_NEW_STATUS: assert property (@(posedge clk) disable iff (rst)
    dbg_take |-> (dbg_status[3:0] == 4'(DBG_LEVEL) && dbg_status[4])); // R10
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
    !dbg_take |-> ($stable(dbg_epc) && $stable(dbg_eps) && $stable(dbg_cause)
                   && $stable(dbg_status))); // R11
endmodule

bind dbrk_unit dbrk_unit_chk #(
  .NUM_BP(NUM_BP), .AW(AW), .DBG_LEVEL(DBG_LEVEL), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_pc(acc_pc),
  .acc_status(acc_status), .bp_hit(bp_hit), .dbg_take(dbg_take),
  .dbg_cause(dbg_cause), .dbg_epc(dbg_epc), .dbg_eps(dbg_eps),
  .dbg_status(dbg_status)
);

// File: tb/dbrk_unit_bench.sv
module dbrk_unit_bench;
  localparam int AW = 32;
  localparam int LVL = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [AW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [2:0]    rd_addr = '0;
  logic [AW-1:0] rd_data;
  logic          acc_valid = 1'b0;
  logic          acc_store = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [AW-1:0] acc_pc = '0;
  logic [AW-1:0] acc_status = '0;
  logic          bp_hit, dbg_take;
  logic [AW-1:0] dbg_cause, dbg_epc, dbg_eps, dbg_status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbrk_unit u_dbrk_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
    .acc_pc(acc_pc), .acc_status(acc_status), .bp_hit(bp_hit),
    .dbg_take(dbg_take), .dbg_cause(dbg_cause), .dbg_epc(dbg_epc),
    .dbg_eps(dbg_eps), .dbg_status(dbg_status)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [AW-1:0] exp);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rd_data, exp);
  endtask

  task automatic access(input logic [AW-1:0] a, input logic st,
                        input logic [AW-1:0] pc, input logic [AW-1:0] sr);
    @(negedge clk);
    acc_valid = 1'b1; acc_store = st; acc_addr = a; acc_pc = pc; acc_status = sr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // leading-ones count of the field gives the repaired mask
  function automatic logic [AW-1:0] exp_mask(input logic [5:0] f);
    int k = 0;
    while (k < 6 && f[5-k]) k++;
    return ~((32'd1 << (6 - k)) - 32'd1);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 bp_hit", {31'd0, bp_hit}, 32'd0);
    chk("R1 dbg_take", {31'd0, dbg_take}, 32'd0);
    chk("R1 dbg_status", dbg_status, 32'd0);
    for (int a = 0; a < 8; a++) rd_chk("R1 readback", 3'(a), 32'd0);

    // R2 register map and readback
    wr(3'd1, 32'hDEAD_BEE0);
    wr(3'd3, 32'hFFFF_FFFF);
    rd_chk("R2 addr1", 3'd1, 32'hDEAD_BEE0);
    rd_chk("R2 ctrl1 unused bits", 3'd3, 32'hC000_003F);
    wr(3'd4, 32'h1234_5678);
    wr(3'd7, 32'h1234_5678);
    rd_chk("R2 cause write ignored", 3'd4, 32'd0);
    rd_chk("R2 eps write ignored", 3'd7, 32'd0);
    wr(3'd3, 32'h0);

    // R3/R4 sweep of all mask codes on breakpoint 0
    wr(3'd0, 32'h0000_A5C0);
    for (int f = 0; f < 64; f++) begin
      logic [AW-1:0] m;
      string tag;
      m = exp_mask(6'(f));
      tag = (6'(f) == m[5:0]) ? "R3 contiguous mask" : "R4 repaired mask";
      wr(3'd2, 32'h8000_0000 | 32'(f));
      for (int j = -1; j < 8; j++) begin
        logic [AW-1:0] a;
        a = (j < 0) ? 32'h0000_A5C0 : (32'h0000_A5C0 ^ (32'd1 << j));
        access(a, 1'b0, 32'h100, 32'h0);
        chk(tag, {31'd0, bp_hit}, {31'd0, ((a ^ 32'h0000_A5C0) & m) == 32'd0});
      end
    end

    // R5 direction enables, exact mask
    wr(3'd2, 32'h4000_003F);               // store only
    access(32'h0000_A5C0, 1'b0, 32'h200, 32'h0);
    chk("R5 load blocked by store-only", {31'd0, bp_hit}, 32'd0);
    access(32'h0000_A5C0, 1'b1, 32'h204, 32'h0);
    chk("R5 store hits", {31'd0, bp_hit}, 32'd1);
    wr(3'd2, 32'h8000_003F);               // load only
    access(32'h0000_A5C0, 1'b1, 32'h208, 32'h0);
    chk("R5 store blocked by load-only", {31'd0, bp_hit}, 32'd0);
    wr(3'd2, 32'h0000_003F);               // inactive
    access(32'h0000_A5C0, 1'b0, 32'h20C, 32'h0);
    chk("R5 inactive load", {31'd0, bp_hit}, 32'd0);
    access(32'h0000_A5C0, 1'b1, 32'h210, 32'h0);
    chk("R5 inactive store", {31'd0, bp_hit}, 32'd0);

    // R6 no hit without valid, pulse width
    wr(3'd2, 32'hC000_0030);               // 16-byte window, both dirs
    @(negedge clk);
    acc_addr = 32'h0000_A5C4; acc_valid = 1'b0;
    @(negedge clk);
    chk("R6 no hit without valid", {31'd0, bp_hit}, 32'd0);
    access(32'h0000_A5C4, 1'b1, 32'h300, 32'h0);
    chk("R6 hit next cycle", {31'd0, bp_hit}, 32'd1);
    @(negedge clk);
    chk("R6 hit drops", {31'd0, bp_hit}, 32'd0);

    // R8 both match: primary 0, vector 2'b11
    wr(3'd1, 32'h0000_A5C8);
    wr(3'd3, 32'hC000_003F);
    access(32'h0000_A5C8, 1'b0, 32'h400, 32'h0000_0002);
    chk("R8 take both", {31'd0, dbg_take}, 32'd1);
    chk("R8 cause both", dbg_cause, 32'h0003_0001);
    // only breakpoint 1
    wr(3'd2, 32'h4000_003F);               // bp0 store-only exact on A5C0
    access(32'h0000_A5C8, 1'b0, 32'h404, 32'h0000_0001);
    chk("R8 cause bp1", dbg_cause, 32'h0002_0101);

    // R9/R10 saved state and new status
    access(32'h0000_A5C8, 1'b0, 32'h8000_1234, 32'hABCD_0025);
    chk("R9 epc", dbg_epc, 32'h8000_1234);
    chk("R9 eps", dbg_eps, 32'hABCD_0025);
    chk("R10 new status", dbg_status, 32'hABCD_0036);
    rd_chk("R9 epc readback", 3'd5, 32'h8000_1234);
    rd_chk("R9 eps readback", 3'd6, 32'hABCD_0025);
    rd_chk("R8 cause readback", 3'd4, 32'h0002_0101);

    // R7 level gating at the threshold, R11 state held
    access(32'h0000_A5C8, 1'b0, 32'h5555_0000, 32'h0000_0006);
    chk("R7 hit at debug level", {31'd0, bp_hit}, 32'd1);
    chk("R7 no take at debug level", {31'd0, dbg_take}, 32'd0);
    chk("R11 epc held", dbg_epc, 32'h8000_1234);
    chk("R11 status held", dbg_status, 32'hABCD_0036);
    access(32'h0000_A5C8, 1'b0, 32'h5555_0004, 32'h0000_000F);
    chk("R7 no take above level", {31'd0, dbg_take}, 32'd0);
    chk("R11 cause held", dbg_cause, 32'h0002_0101);
    access(32'h0000_A5C8, 1'b0, 32'h5555_0008, 32'h0000_0005);
    chk("R7 take below level", {31'd0, dbg_take}, 32'd1);
    chk("R10 status from level 5", dbg_status, 32'h0000_0016);
    access(32'h0000_0000, 1'b0, 32'h6666_0000, 32'h0000_0000);
    chk("R11 miss keeps epc", dbg_epc, 32'h5555_0008);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule